// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of binary lock flags that two independent agents, called left and right, share. Each agent sees the bank through its own port. The bank is a separate address space. An access reaches it only when the port's semaphore select is high and its chip select is low. When both selects are high, the access is an illegal mix and has no effect.

Each flag keeps one request latch per side and an owner state. Writing a zero in bit 0 asks for the token, and writing a one gives it up. The token goes to the side that asks first. If the other side asks while the flag is held, its request waits in its latch. When the owner releases, the waiting request takes the token without further action. A read returns the side's own view of the flag on every data bit: all zeros means "this side holds the token" and all ones means "it does not". The read value is latched when a read starts and stays fixed while the read is held. Software that polls must therefore end the read and start it again. Nothing in the block uses the flags to guard any hardware resource; their meaning is left to software.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous reset, every flag is free, both request latches of every flag are one, and both read buses show all ones.
- R2: Only address bits [2:0] pick one of the eight flags during an access. All higher address bits are ignored.
- R3: A write uses only data bit 0. A read drives the flag view on all 16 data bits, so the bus is either 16'h0000 or 16'hFFFF.
- R4: A zero written to a free flag gives the token to the writer. The writer then reads 16'h0000 and the other side reads 16'hFFFF. A one written by the side that does not own the flag does not change the owner.
- R5: A zero written by the non-owning side is kept in its latch. When the owner writes a one, the token moves to the waiting side in the same clock edge, and that side then reads 16'h0000. A waiting side that writes a one before the handover withdraws its request, and the owner's release then leaves the flag free.
- R6: If both sides write zero to a free flag on the same clock edge, the left side gets the token.
- R7: The read bus is loaded on the first edge at which semaphore select and read enable are both high, with chip select low. It keeps that value, even if the flag changes, until one of those signals drops. It then holds until the next read starts.
- R8: Any access made with chip select high is ignored: a write changes no flag, and a read leaves the read bus unchanged.
- R9: A side whose latch holds a pending zero while the other side owns the flag reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_cs | input | 1 | Left chip select; high blocks semaphore access |
| l_sem_sel | input | 1 | Left semaphore space select |
| l_rd_en | input | 1 | Left read (output) enable |
| l_wr_en | input | 1 | Left write enable |
| l_addr | input | 14 | Left address; bits [2:0] pick the flag |
| l_wdata | input | 16 | Left write data; bit 0 used |
| l_rdata | output | 16 | Left registered read data |
| r_cs | input | 1 | Right chip select; high blocks semaphore access |
| r_sem_sel | input | 1 | Right semaphore space select |
| r_rd_en | input | 1 | Right read (output) enable |
| r_wr_en | input | 1 | Right write enable |
| r_addr | input | 14 | Right address; bits [2:0] pick the flag |
| r_wdata | input | 16 | Right write data; bit 0 used |
| r_rdata | output | 16 | Right registered read data |

## Verification
The hardest cases to reach are a release and a new request landing on the same edge, and a held read that must not follow a change it could see. The handover scenario first builds a pending right request behind a left owner. It also checks a withdrawn request, where the release must leave the flag free. The freeze scenario holds a left read open while the left side takes the token in the same open window. It then checks that the bus keeps the old all-ones value until the read is stopped and started again. A one-cycle scenario drives both ports at once to test the tie rule.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } owner_t;
endpackage

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_wr,
  input  logic l_bit,
  input  logic r_wr,
  input  logic r_bit,
  output logic l_view,
  output logic r_view
);
  logic   lat_l, lat_r, lat_l_n, lat_r_n;
  owner_t owner, owner_n;

  assign lat_l_n = l_wr ? l_bit : lat_l;
  assign lat_r_n = r_wr ? r_bit : lat_r;

  always_comb begin
    owner_n = owner;
    unique case (owner)
      OWN_FREE: begin
        if (!lat_l_n)      owner_n = OWN_L;   // left wins a tie
        else if (!lat_r_n) owner_n = OWN_R;
      end
      OWN_L: if (lat_l_n) owner_n = lat_r_n ? OWN_FREE : OWN_R;
      OWN_R: if (lat_r_n) owner_n = lat_l_n ? OWN_FREE : OWN_L;
      default: owner_n = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_l <= 1'b1;
      lat_r <= 1'b1;
      owner <= OWN_FREE;
    end else begin
      lat_l <= lat_l_n;
      lat_r <= lat_r_n;
      owner <= owner_n;
    end
  end

  assign l_view = (owner != OWN_L);
  assign r_view = (owner != OWN_R);

  assert_keep_left_R4: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_L && !(l_wr && l_bit)) |=> owner == OWN_L);
  assert_keep_right_R4: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_R && !(r_wr && r_bit)) |=> owner == OWN_R);
  assert_handoff_R5: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_L && l_wr && l_bit && !lat_r && !(r_wr && r_bit)) |=> owner == OWN_R);
  assert_tie_left_R6: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_FREE && l_wr && !l_bit && r_wr && !r_bit) |=> owner == OWN_L);
endmodule

// File: rtl/sem_port.sv
module sem_port #(
  parameter int NFLAG  = 8,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(NFLAG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sem_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NFLAG-1:0]  view,
  output logic [NFLAG-1:0]  wr_vec,
  output logic              wbit,
  output logic [DATA_W-1:0] rdata
);
  logic             acc, rd_act, rd_prev;
  logic [SEL_W-1:0] idx;
  logic             unused_bits;

  assign acc    = sem_sel && !cs;
  assign idx    = addr[SEL_W-1:0];
  assign wbit   = wdata[0];
  assign rd_act = acc && rd_en;
  assign unused_bits = ^{addr[ADDR_W-1:SEL_W], wdata[DATA_W-1:1]};

  for (genvar g = 0; g < NFLAG; g++) begin : g_dec
    assign wr_vec[g] = acc && wr_en && (idx == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      rdata   <= '1;
    end else begin
      rd_prev <= rd_act;
      if (rd_act && !rd_prev) rdata <= {DATA_W{view[idx]}};
    end
  end

  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_act && rd_prev) |=> $stable(rdata));
  assert_replicated_R3: assert property (@(posedge clk) disable iff (rst)
    (rdata == '0) || (rdata == '1));
  assert_cs_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    cs |-> (wr_vec == '0));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NFLAG  = 8,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_cs,
  input  logic              l_sem_sel,
  input  logic              l_rd_en,
  input  logic              l_wr_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_cs,
  input  logic              r_sem_sel,
  input  logic              r_rd_en,
  input  logic              r_wr_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NFLAG-1:0] l_view, r_view, l_wr_vec, r_wr_vec;
  logic             l_bit, r_bit;

  sem_port #(.NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lport (
    .clk(clk), .rst(rst), .cs(l_cs), .sem_sel(l_sem_sel), .rd_en(l_rd_en),
    .wr_en(l_wr_en), .addr(l_addr), .wdata(l_wdata), .view(l_view),
    .wr_vec(l_wr_vec), .wbit(l_bit), .rdata(l_rdata));

  sem_port #(.NFLAG(NFLAG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rport (
    .clk(clk), .rst(rst), .cs(r_cs), .sem_sel(r_sem_sel), .rd_en(r_rd_en),
    .wr_en(r_wr_en), .addr(r_addr), .wdata(r_wdata), .view(r_view),
    .wr_vec(r_wr_vec), .wbit(r_bit), .rdata(r_rdata));

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .l_wr(l_wr_vec[g]), .l_bit(l_bit),
      .r_wr(r_wr_vec[g]), .r_bit(r_bit),
      .l_view(l_view[g]), .r_view(r_view[g]));
  end

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    (l_view | r_view) == '1);
endmodule

// File: tb/sim_sem_bank.sv
`timescale 1ns/1ps
module sim_sem_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic        l_cs = 0, l_sem = 0, l_rd = 0, l_wr = 0;
  logic [13:0] l_addr = '0;
  logic [15:0] l_wdata = '0;
  logic        r_cs = 0, r_sem = 0, r_rd = 0, r_wr = 0;
  logic [13:0] r_addr = '0;
  logic [15:0] r_wdata = '0;
  logic [15:0] l_rdata, r_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sem_bank u0 (
    .clk(clk), .rst(rst),
    .l_cs(l_cs), .l_sem_sel(l_sem), .l_rd_en(l_rd), .l_wr_en(l_wr),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_cs(r_cs), .r_sem_sel(r_sem), .r_rd_en(r_rd), .r_wr_en(r_wr),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_all();
    l_cs = 0; l_sem = 0; l_rd = 0; l_wr = 0;
    r_cs = 0; r_sem = 0; r_rd = 0; r_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_all(); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  // side 0 = left, 1 = right
  task automatic wr(input bit side, input logic [13:0] a, input logic [15:0] d, input bit cs = 0);
    @(negedge clk);
    if (!side) begin l_cs = cs; l_sem = 1; l_wr = 1; l_addr = a; l_wdata = d; end
    else       begin r_cs = cs; r_sem = 1; r_wr = 1; r_addr = a; r_wdata = d; end
    @(negedge clk);
    idle_all();
  endtask

  task automatic rd(input bit side, input logic [13:0] a, input logic [15:0] exp,
                    input string tag, input bit cs = 0);
    @(negedge clk);
    if (!side) begin l_cs = cs; l_sem = 1; l_rd = 1; l_addr = a; end
    else       begin r_cs = cs; r_sem = 1; r_rd = 1; r_addr = a; end
    @(negedge clk);
    chk(tag, side ? r_rdata : l_rdata, exp);
    idle_all();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 left bus after reset", l_rdata, 16'hFFFF);
    chk("R1 right bus after reset", r_rdata, 16'hFFFF);
    for (int i = 0; i < 8; i++) rd(0, 14'(i), 16'hFFFF, "R1 flag free after reset");
  endtask

  task automatic t_basic();
    do_reset();
    wr(0, 14'h3FF5, 16'hFFFE);             // R2 R3: high addr bits and data bits ignored
    rd(0, 14'h2005, 16'h0000, "R2 left owns flag 5 via other high bits");
    rd(0, 14'h0004, 16'hFFFF, "R2 flag 4 untouched");
    rd(1, 14'h0005, 16'hFFFF, "R4 other side sees taken flag");
    wr(1, 14'h0005, 16'h0001);             // non-owner release: no effect
    rd(0, 14'h0005, 16'h0000, "R4 non-owner one ignored");
    wr(0, 14'h0005, 16'h0001);
    rd(0, 14'h0005, 16'hFFFF, "R3 release with bit0 one frees flag");
    rd(1, 14'h0005, 16'hFFFF, "R3 right stays all ones");
  endtask

  task automatic t_handoff();
    do_reset();
    wr(0, 14'd2, 16'h0000);
    wr(1, 14'd2, 16'h0000);                // pending
    rd(1, 14'd2, 16'hFFFF, "R9 waiting side reads ones");
    rd(0, 14'd2, 16'h0000, "R5 owner keeps token");
    wr(0, 14'd2, 16'h0001);
    rd(1, 14'd2, 16'h0000, "R5 token handed to waiter");
    rd(0, 14'd2, 16'hFFFF, "R5 old owner reads ones");
    // withdrawal path on flag 6
    wr(1, 14'd6, 16'h0000);
    wr(0, 14'd6, 16'h0000);
    wr(0, 14'd6, 16'h0001);                // withdraw pending left request
    wr(1, 14'd6, 16'h0001);
    rd(0, 14'd6, 16'hFFFF, "R5 withdrawn request not granted");
    wr(0, 14'd6, 16'h0000);
    rd(0, 14'd6, 16'h0000, "R5 flag free after withdraw then release");
  endtask

  task automatic t_tie();
    do_reset();
    @(negedge clk);
    l_sem = 1; l_wr = 1; l_addr = 14'd1; l_wdata = 16'h0;
    r_sem = 1; r_wr = 1; r_addr = 14'd1; r_wdata = 16'h0;
    @(negedge clk); idle_all();
    rd(0, 14'd1, 16'h0000, "R6 left wins tie");
    rd(1, 14'd1, 16'hFFFF, "R6 right loses tie");
    wr(0, 14'd1, 16'h0001);
    rd(1, 14'd1, 16'h0000, "R6 right pending from tie gets token");
  endtask

  task automatic t_freeze();
    do_reset();
    @(negedge clk);
    l_sem = 1; l_rd = 1; l_addr = 14'd3;
    @(negedge clk);
    chk("R7 captured free value", l_rdata, 16'hFFFF);
    l_wr = 1; l_wdata = 16'h0;              // acquire while read held
    @(negedge clk); l_wr = 0;
    @(negedge clk);
    chk("R7 held read stays frozen", l_rdata, 16'hFFFF);
    idle_all();
    @(negedge clk);
    chk("R7 bus holds after read ends", l_rdata, 16'hFFFF);
    rd(0, 14'd3, 16'h0000, "R7 new read sees token");
  endtask

  task automatic t_cs();
    do_reset();
    wr(0, 14'd7, 16'h0000);
    rd(0, 14'd7, 16'h0000, "R8 setup owned");
    rd(0, 14'd0, 16'h0000, "R8 read with cs high leaves bus", 1);
    wr(1, 14'd0, 16'h0000, 1);             // ignored write
    rd(1, 14'd0, 16'hFFFF, "R8 write with cs high ignored");
    rd(0, 14'd0, 16'hFFFF, "R8 flag 0 still free");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_handoff();
    t_tie();
    t_freeze();
    t_cs();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule